// File: doc/BRIEF.md
# Pipelined Dual-Halfword Dot-Product Engine

This block computes the sum of products of two vectors of signed 16-bit samples that sit in a synchronous memory. The memory has one-cycle read latency. A command supplies three things: an element count, a base word address for each vector, and a word address for the result. The engine then reads both vectors in lockstep through two read ports, one word per port per cycle. The fetch, multiply and accumulate stages overlap, so a new operand pair enters the pipeline every cycle. After a short drain the 32-bit sum is written out through a single write port.

In the default mode each 32-bit word carries one sample in its low halfword. In paired mode each word carries two samples, and both lane products are added into the running sum in the same cycle. This halves the number of reads for a given element count. The host pulses `start` while the engine is idle, then waits for `done`.

Top module: `dotprod_engine`

## Requirements
- R1: Each product is the full 32-bit product of two signed 16-bit samples. In default mode the sample is bits [15:0] of the word, and bits [31:16] have no effect.
- R2: The running sum starts from zero for every accepted command, whatever earlier commands produced.
- R3: A command reads `count` words per vector in default mode and `count/2` words in paired mode. `rda_en`/`rdx_en` are high for exactly that many consecutive cycles, starting in the cycle after the start edge.
- R4: The read addresses start at `a_base` and `x_base` and advance by one word per read.
- R5: Taking the start edge as edge 0, a command with N reads (N > 0) presents its result write in the cycle after edge N+2.
- R6: In paired mode, lane 0 is bits [15:0] and lane 1 is bits [31:16]. Each read adds a0*x0 + a1*x1 to the sum.
- R7: The result is written with `wr_en` high for exactly one cycle, at the `res_addr` captured at start.
- R8: The sum wraps modulo 2^32 with no saturation.
- R9: A count of zero performs no reads and writes zero in the cycle right after the start edge.
- R10: `done` is high for exactly the one cycle after the write cycle. `busy` is high from the cycle after the start edge through the write cycle, and is low in the `done` cycle.
- R11: `start` is ignored while `busy` is high, including in the write cycle. A `start` in the `done` cycle is accepted.
- R12: A paired-mode command with an odd count is rejected. `err` goes high for the one cycle after the start edge, and no read, write or `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, sampled while idle |
| count | input | CNT_W | Element count |
| paired | input | 1 | 1 = two halfword samples per word |
| a_base | input | ADDR_W | First word address of vector A |
| x_base | input | ADDR_W | First word address of vector X |
| res_addr | input | ADDR_W | Word address for the result |
| rda_en | output | 1 | Read enable, vector A port |
| rda_addr | output | ADDR_W | Read address, vector A port |
| rda_data | input | 2*DATA_W | Read data, one cycle after enable |
| rdx_en | output | 1 | Read enable, vector X port |
| rdx_addr | output | ADDR_W | Read address, vector X port |
| rdx_data | input | 2*DATA_W | Read data, one cycle after enable |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | ADDR_W | Result write address |
| wr_data | output | 2*DATA_W | Result value |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |

## Verification
Two events can fall in the same cycle: a new `start` and the write of the previous result (or the `done` that follows it). The bench holds `start` high with unrelated command fields for every cycle that `busy` is high, including the write cycle. It then judges that the result value, address and latency match the original command alone. It also issues each next command in the `done` cycle of the previous one, and judges that it is accepted with its own latency and a sum that starts from zero. Default and paired sweeps over many counts, plus all-minimum samples that force wraparound, cover the arithmetic.

// File: rtl/dp_pkg.sv
package dp_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dp_state_e;
endpackage

// File: rtl/dp_fetch.sv
module dp_fetch #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_a,
  input  logic [ADDR_W-1:0] ld_x,
  input  logic [CNT_W-1:0]  ld_n,
  output logic [ADDR_W-1:0] a_addr,
  output logic [ADDR_W-1:0] x_addr,
  output logic              rd_en,
  output logic              rd_last
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en  <= 1'b0;
      rem_q  <= '0;
      a_addr <= '0;
      x_addr <= '0;
    end else if (load) begin
      a_addr <= ld_a;
      x_addr <= ld_x;
      rem_q  <= ld_n;
      rd_en  <= (ld_n != '0);
    end else if (rd_en) begin
      a_addr <= a_addr + 1'b1;
      x_addr <= x_addr + 1'b1;
      rem_q  <= rem_q - 1'b1;
      rd_en  <= (rem_q != CNT_W'(1));
    end
  end

  assign rd_last = rd_en && (rem_q == CNT_W'(1));

  // R3: reads never run past the loaded count
  p_rem_live_r3: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> rem_q != '0);
  // R4: consecutive reads step by one word
  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    rd_en && $past(rd_en) |-> a_addr == $past(a_addr) + 1'b1 && x_addr == $past(x_addr) + 1'b1);
endmodule

// File: rtl/dp_mac.sv
module dp_mac #(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                paired,
  input  logic                issue,
  input  logic                issue_last,
  input  logic [2*DATA_W-1:0] a_word,
  input  logic [2*DATA_W-1:0] x_word,
  output logic                res_vld,
  output logic [2*DATA_W-1:0] res
);
  localparam int WORD_W = 2 * DATA_W;
  localparam int ACC_W  = 2 * DATA_W;
  localparam int LANES  = WORD_W / DATA_W;

  logic                   d_vld, d_last, m_vld, m_last;
  logic [LANES*ACC_W-1:0] lane_p, prod_q;
  logic [ACC_W-1:0]       psum, acc_q;

  // operand stage: data arrives one cycle after the read strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      d_vld  <= 1'b0;
      d_last <= 1'b0;
    end else begin
      d_vld  <= issue;
      d_last <= issue_last;
    end
  end

  genvar g;
  for (g = 0; g < LANES; g++) begin : g_lane
    logic signed [DATA_W-1:0] av, xv;
    logic signed [ACC_W-1:0]  ae, xe;
    logic                     lane_on;
    assign av      = a_word[g*DATA_W +: DATA_W];
    assign xv      = x_word[g*DATA_W +: DATA_W];
    assign ae      = ACC_W'(av);
    assign xe      = ACC_W'(xv);
    assign lane_on = (g == 0) || paired;
    assign lane_p[g*ACC_W +: ACC_W] = lane_on ? ae * xe : '0;
  end

  // multiply stage
  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      m_vld  <= 1'b0;
      m_last <= 1'b0;
    end else begin
      m_vld  <= d_vld;
      m_last <= d_last;
      if (d_vld) prod_q <= lane_p;
    end
  end

  always_comb begin
    psum = '0;
    for (int i = 0; i < LANES; i++) psum = psum + prod_q[i*ACC_W +: ACC_W];
  end

  // accumulate stage
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      res_vld <= 1'b0;
      res     <= '0;
    end else begin
      res_vld <= m_vld && m_last;
      if (clear) acc_q <= '0;
      else if (m_vld) acc_q <= acc_q + psum;
      if (m_vld && m_last) res <= acc_q + psum;
    end
  end

  // R2: the sum restarts from zero on every accepted command
  p_acc_clear_r2: assert property (@(posedge clk) disable iff (rst)
    clear |=> acc_q == '0);
  // R7: one result per command
  p_res_single_r7: assert property (@(posedge clk) disable iff (rst)
    res_vld |=> !res_vld);
endmodule

// File: rtl/dp_ctrl.sv
module dp_ctrl
  import dp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  count,
  input  logic              paired,
  input  logic [ADDR_W-1:0] res_addr,
  input  logic              mac_vld,
  output logic              accept,
  output logic [CNT_W-1:0]  iters,
  output logic              paired_q,
  output logic              zero_wr,
  output logic [ADDR_W-1:0] wr_addr_q,
  output logic              busy,
  output logic              done,
  output logic              err
);
  dp_state_e state_q;
  logic      reject;
  logic      wr_now;

  assign reject = paired && count[0];
  assign accept = start && (state_q == ST_IDLE) && !reject;
  assign iters  = paired ? (count >> 1) : count;
  assign busy   = (state_q == ST_RUN);
  assign wr_now = mac_vld || zero_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      paired_q  <= 1'b0;
      zero_wr   <= 1'b0;
      wr_addr_q <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done    <= 1'b0;
      err     <= 1'b0;
      zero_wr <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start && reject) begin
            err <= 1'b1;
          end else if (accept) begin
            state_q   <= ST_RUN;
            paired_q  <= paired;
            wr_addr_q <= res_addr;
            zero_wr   <= (count == '0);
          end
        end
        default: begin
          if (wr_now) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end
        end
      endcase
    end
  end

  // R10: done is a single-cycle pulse right after the write
  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_after_write_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(wr_now));
  // R11: a command in flight keeps its result address until it writes
  p_busy_hold_r11: assert property (@(posedge clk) disable iff (rst)
    busy && !wr_now |=> busy && $stable(wr_addr_q));
  // R12: a rejected command never starts
  p_err_idle_r12: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy);
endmodule

// File: rtl/dotprod_engine.sv
module dotprod_engine #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [CNT_W-1:0]    count,
  input  logic                paired,
  input  logic [ADDR_W-1:0]   a_base,
  input  logic [ADDR_W-1:0]   x_base,
  input  logic [ADDR_W-1:0]   res_addr,
  output logic                rda_en,
  output logic [ADDR_W-1:0]   rda_addr,
  input  logic [2*DATA_W-1:0] rda_data,
  output logic                rdx_en,
  output logic [ADDR_W-1:0]   rdx_addr,
  input  logic [2*DATA_W-1:0] rdx_data,
  output logic                wr_en,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [2*DATA_W-1:0] wr_data,
  output logic                busy,
  output logic                done,
  output logic                err
);
  localparam int WORD_W = 2 * DATA_W;

  logic              accept, paired_q, zero_wr;
  logic [CNT_W-1:0]  iters;
  logic              rd_en, rd_last;
  logic              mac_vld;
  logic [WORD_W-1:0] mac_res;

  dp_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .count(count), .paired(paired),
    .res_addr(res_addr), .mac_vld(mac_vld), .accept(accept), .iters(iters),
    .paired_q(paired_q), .zero_wr(zero_wr), .wr_addr_q(wr_addr),
    .busy(busy), .done(done), .err(err)
  );

  dp_fetch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fetch (
    .clk(clk), .rst(rst), .load(accept), .ld_a(a_base), .ld_x(x_base),
    .ld_n(iters), .a_addr(rda_addr), .x_addr(rdx_addr),
    .rd_en(rd_en), .rd_last(rd_last)
  );

  dp_mac #(.DATA_W(DATA_W)) u_mac (
    .clk(clk), .rst(rst), .clear(accept), .paired(paired_q),
    .issue(rd_en), .issue_last(rd_last), .a_word(rda_data), .x_word(rdx_data),
    .res_vld(mac_vld), .res(mac_res)
  );

  assign rda_en  = rd_en;
  assign rdx_en  = rd_en;
  assign wr_en   = mac_vld || zero_wr;
  assign wr_data = mac_vld ? mac_res : '0;

  // R5: the write comes only after the read phase has ended
  p_write_after_reads_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !rda_en);
  // R9: a zero-count command writes zero
  p_zero_result_r9: assert property (@(posedge clk) disable iff (rst)
    wr_en && !mac_vld |-> wr_data == '0);
endmodule

// File: tb/test_dotprod_engine.sv
`timescale 1ns/1ps
module test_dotprod_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  count = '0;
  logic        paired = 1'b0;
  logic [7:0]  a_base = '0, x_base = '0, res_addr = '0;
  logic        rda_en, rdx_en, wr_en, busy, done, err;
  logic [7:0]  rda_addr, rdx_addr, wr_addr;
  logic [31:0] rda_data = '0, rdx_data = '0, wr_data;

  logic [31:0] a_mem [256];
  logic [31:0] x_mem [256];

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  dotprod_engine i_dotprod_engine (
    .clk(clk), .rst(rst), .start(start), .count(count), .paired(paired),
    .a_base(a_base), .x_base(x_base), .res_addr(res_addr),
    .rda_en(rda_en), .rda_addr(rda_addr), .rda_data(rda_data),
    .rdx_en(rdx_en), .rdx_addr(rdx_addr), .rdx_data(rdx_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .err(err)
  );

  always @(posedge clk) begin
    if (rda_en) rda_data <= a_mem[rda_addr];
    if (rdx_en) rdx_data <= x_mem[rdx_addr];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_sum(input int iters, input bit pr, input int ab, input int xb);
    logic [31:0] s = '0;
    for (int i = 0; i < iters; i++) begin
      logic [31:0] aw, xw;
      int pa, pb;
      aw = a_mem[ab + i];
      xw = x_mem[xb + i];
      pa = int'($signed(aw[15:0]));
      pb = int'($signed(xw[15:0]));
      s  = s + 32'(pa * pb);
      if (pr) begin
        pa = int'($signed(aw[31:16]));
        pb = int'($signed(xw[31:16]));
        s  = s + 32'(pa * pb);
      end
    end
    return s;
  endfunction

  task automatic run_cmd(input int n, input bit pr, input int ab, input int xb,
                         input int ra, input bit inj, input string tag);
    int iters, reads, wrk;
    bit seen_done;
    logic [31:0] exp;
    iters = pr ? n / 2 : n;
    exp   = expect_sum(iters, pr, ab, xb);
    count = 8'(n); paired = pr; a_base = 8'(ab); x_base = 8'(xb); res_addr = 8'(ra);
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    if (pr && (n % 2 == 1)) begin
      chk(err == 1'b1, "R12 err pulse", 32'(err), 32'd1);
      chk(!rda_en && !busy, "R12 no start", 32'({rda_en, busy}), 32'd0);
      @(posedge clk); @(negedge clk);
      chk(!err && !done && !wr_en && !rda_en, "R12 nothing follows",
          32'({err, done, wr_en, rda_en}), 32'd0);
      return;
    end
    if (inj) begin
      count = 8'd3; paired = 1'b0; a_base = 8'd0; x_base = 8'd1; res_addr = 8'hEE;
    end
    reads = 0; wrk = -1; seen_done = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (inj) start = busy;
      if (wrk >= 0) begin
        chk(done == 1'b1, "R10 done after write", 32'(done), 32'd1);
        chk(busy == 1'b0, "R10 busy low in done cycle", 32'(busy), 32'd0);
        chk(wr_en == 1'b0, "R7 single write", 32'(wr_en), 32'd0);
        seen_done = 1'b1;
        break;
      end
      if (done) chk(1'b0, "R10 early done", 32'(k), 32'(wrk));
      if (rda_en) begin
        chk(rda_addr == 8'(ab + reads) && rdx_addr == 8'(xb + reads), "R4 read address",
            32'({rda_addr, rdx_addr}), 32'({8'(ab + reads), 8'(xb + reads)}));
        reads++;
      end
      if (wr_en) begin
        wrk = k;
        chk(wr_data == exp, tag, wr_data, exp);
        chk(wr_addr == 8'(ra), "R7 result address", 32'(wr_addr), 32'(ra));
        chk(busy == 1'b1, "R10 busy in write cycle", 32'(busy), 32'd1);
      end
      @(posedge clk); @(negedge clk);
    end
    start = 1'b0;
    chk(reads == iters, pr ? "R3 R6 paired read count" : "R3 read count", 32'(reads), 32'(iters));
    chk(wrk == ((iters == 0) ? 0 : iters + 2), (iters == 0) ? "R9 zero latency" : "R5 latency",
        32'(wrk), 32'((iters == 0) ? 0 : iters + 2));
    chk(seen_done, "R10 done seen", 32'(seen_done), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R5 watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] s;
    s = 32'h1234_5678;
    for (int i = 0; i < 256; i++) begin
      s = s * 32'd1103515245 + 32'd12345;
      a_mem[i] = s;
      s = s * 32'd1103515245 + 32'd12345;
      x_mem[i] = {s[15:0], s[31:16]};
    end
    for (int i = 200; i < 216; i++) begin
      a_mem[i] = 32'h8000_8000;
      x_mem[i] = 32'h8000_8000;
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !err, "R10 reset idle", 32'({busy, done, err}), 32'd0);
    chk(!rda_en && !rdx_en, "R3 reset no reads", 32'({rda_en, rdx_en}), 32'd0);
    chk(!wr_en, "R7 reset no write", 32'(wr_en), 32'd0);

    // default mode sweep; each command starts in the done cycle of the previous (R2, R11)
    for (int n = 0; n <= 12; n++) run_cmd(n, 1'b0, 3 * n, 100 + n, n, 1'b0, "R1 R2 default sum");
    // paired mode sweep
    for (int n = 0; n <= 14; n += 2) run_cmd(n, 1'b1, 50 + n, 140 - n, 40 + n, 1'b0, "R6 R2 paired sum");
    // odd paired counts are rejected
    run_cmd(1, 1'b1, 0, 0, 9, 1'b0, "R12");
    run_cmd(3, 1'b1, 0, 0, 9, 1'b0, "R12");
    run_cmd(7, 1'b1, 0, 0, 9, 1'b0, "R12");
    // a good command right after a rejection still starts from zero
    run_cmd(5, 1'b0, 10, 20, 77, 1'b0, "R2 sum after reject");
    // wraparound: 3 * 2^30 and 2 * 2^31
    run_cmd(3, 1'b0, 200, 200, 90, 1'b0, "R8 default wrap");
    run_cmd(4, 1'b1, 200, 204, 91, 1'b0, "R8 paired wrap");
    run_cmd(16, 1'b1, 200, 200, 92, 1'b0, "R8 paired long wrap");
    // start held high through the whole run, including the write cycle
    run_cmd(10, 1'b0, 30, 60, 120, 1'b1, "R11 default sum under start");
    run_cmd(8, 1'b1, 70, 5, 121, 1'b1, "R11 paired sum under start");
    run_cmd(0, 1'b0, 0, 0, 122, 1'b1, "R11 R9 zero under start");
    // upper halfword ignored in default mode: same low halves, different upper halves
    a_mem[180] = 32'h7FFF_0003; x_mem[180] = 32'h1234_FFFE;
    a_mem[181] = 32'h0000_0003; x_mem[181] = 32'h0000_FFFE;
    run_cmd(1, 1'b0, 180, 180, 123, 1'b0, "R1 upper half ignored");
    run_cmd(1, 1'b0, 181, 181, 124, 1'b0, "R1 low half signed");

    @(negedge clk);
    chk(!busy && !done, "R10 idle at end", 32'({busy, done}), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule